// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block gives a flash-driver control chip a two-wire serial target that owns a small map of four byte-wide registers. Three of them (command, dimming and auxiliary) are written and read by the bus master and drive the rest of the chip directly through output ports. The fourth slot is a read-only window onto a status byte produced elsewhere. When that status byte has been read, a one-cycle strobe goes out so the status logic can clear its sticky bits.

The 7-bit target address is fixed in its upper five bits. The two lowest bits come from a four-way board strap, which is sampled only while reset is held. A transfer names a register once. After that, data bytes stream in or out, and an internal pointer advances after every byte in either direction. Reads use a short write phase to set the pointer, then a repeated START with the read flag set. SCL and SDA are brought into the system clock through two-flop synchronizers. The bus is driven only by an open-drain enable, and the target never stretches the clock. An undervoltage input stops the target from acknowledging anything.

Top module: `i2c_reg_target`

## Requirements
- R1: The target answers only to address 0b01100 followed by the two strap bits, with strap_sel[1] in address bit 1 and strap_sel[0] in address bit 0. strap_sel is captured only while rst_n is low, and later changes have no effect.
- R2: An address byte that matches, with bit 0 as R/W and 1 meaning read, is acknowledged by holding SDA low during the ninth SCL pulse. A non-matching address gets no acknowledge, and every following byte is ignored until the next START.
- R3: sda_oe changes only after a falling SCL edge, or on START or STOP. A START or STOP always releases SDA.
- R4: In a write, the byte after the address sets the register pointer. Each following byte, received MSB first, is acknowledged and written into the register at the pointer. Index 0 drives cmd_reg, 1 drives dim_reg and 2 drives aux_reg.
- R5: The pointer takes only the low two bits of the register-address byte. It advances by one after every data byte written or read, wrapping from 3 to 0.
- R6: A data byte written to index 3 is acknowledged but discarded, and all three register outputs keep their values.
- R7: In a read, each byte is driven MSB first, with a new bit after each falling SCL edge. Index 3 returns status_in. An acknowledge from the master continues with the next index. A missing acknowledge ends the read and leaves SDA released.
- R8: stat_rd_pulse goes high for exactly one clock, after the last bit of a byte read from index 3 has been clocked out. It pulses once per such byte.
- R9: After reset, cmd_reg, dim_reg and aux_reg are 0x00 and sda_oe is low.
- R10: While uvlo is high at an acknowledge slot, the target does not acknowledge. It discards that byte and ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; strap is sampled while low |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| strap_sel | input | 2 | Board strap giving the two low address bits |
| uvlo | input | 1 | Undervoltage flag; blocks acknowledges |
| status_in | input | 8 | Status byte returned at index 3 |
| cmd_reg | output | 8 | Command register contents |
| dim_reg | output | 8 | Dimming register contents |
| aux_reg | output | 8 | Auxiliary register contents |
| stat_rd_pulse | output | 1 | One-cycle strobe after a status byte is read |

## Verification
Some properties are checked on every cycle. The strap latch is frozen outside reset. The data-line enable moves only after a falling clock edge or a bus condition. START and STOP always release the line. Register outputs change only on a falling clock edge. The status strobe is a single cycle tied to a falling edge.

Other behaviour needs whole transfers, so only the bench scenarios show it. These cover address matching for each strap value, pointer wrap and aliasing, the discarded write to the status index, bursts of mixed reads, the master's acknowledge ending a read, and undervoltage arriving in the middle of a transfer.

// File: rtl/i2c_tgt_pkg.sv
// Shared constants and types for the register target.
// Assumes a four-entry map whose last index is the read-only status slot.
package i2c_tgt_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 4;
    localparam int PTR_W    = $clog2(NUM_REGS);
    localparam int NUM_RW   = NUM_REGS - 1;
    localparam int BIT_CNT_W = 4;
    localparam logic [PTR_W-1:0] IDX_STATUS = PTR_W'(NUM_REGS - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_REGADR,
        ST_WDATA,
        ST_RDATA
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Brings SCL and SDA into the clock domain and flags bus events.
// Assumes the bus idles high; START and STOP are SDA edges while SCL stays high.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Synchronizer chains, preset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // One-cycle history used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_regs.sv
// Writable registers plus the read multiplexer with the external status slot.
// Assumes the status index is the last one; writes there match no register.
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [PTR_W-1:0]               wr_ptr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [PTR_W-1:0]               rd_ptr,
    input  logic [DATA_W-1:0]              status_in,
    output logic [DATA_W-1:0]              rd_data,
    output logic [NUM_RW-1:0][DATA_W-1:0]  rw_out
);
    logic [NUM_RW-1:0][DATA_W-1:0] rw_q;

    // Register bank: clear on reset, load the addressed entry on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_RW; i++) begin
                if (wr_ptr == PTR_W'(i)) rw_q[i] <= wr_data;
            end
        end
    end

    // Read mux: writable entries by index, otherwise the status byte.
    always_comb begin
        rd_data = status_in;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rd_ptr == PTR_W'(i)) rd_data = rw_q[i];
        end
    end

    assign rw_out = rw_q;
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Byte-level protocol engine: address match, pointer load, write and read bursts.
// Assumes no clock stretching; SDA is driven after each SCL fall and released at STOP/START.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [6:0]        dev_addr,
    input  logic              uvlo,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] shreg,
    output logic              stat_pulse
);
    tgt_state_e            state;
    logic [BIT_CNT_W-1:0]  cnt;
    logic                  ack_ph;
    logic                  rd_req;
    logic                  mack;
    logic [DATA_W-1:0]     txreg;
    logic                  byte_end;

    // Fall that closes the eighth bit of a byte slot.
    assign byte_end = scl_fall && (cnt == BIT_CNT_W'(8)) && !ack_ph;

    // Write strobe for a fully received data byte when acknowledging is allowed.
    assign wr_en = byte_end && (state == ST_WDATA) && !uvlo;

    // Protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            ack_ph     <= 1'b0;
            rd_req     <= 1'b0;
            mack       <= 1'b0;
            txreg      <= '0;
            shreg      <= '0;
            ptr        <= '0;
            sda_oe     <= 1'b0;
            stat_pulse <= 1'b0;
        end else begin
            stat_pulse <= 1'b0;
            if (start_det) begin
                state  <= ST_DEVADR;
                cnt    <= '0;
                ack_ph <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                ack_ph <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEVADR, ST_REGADR, ST_WDATA: begin
                        if (scl_rise && cnt < BIT_CNT_W'(8)) begin
                            shreg <= {shreg[DATA_W-2:0], sda_s};
                            cnt   <= cnt + BIT_CNT_W'(1);
                        end else if (byte_end) begin
                            ack_ph <= 1'b1;
                            if (uvlo) begin
                                state <= ST_IDLE;
                            end else begin
                                case (state)
                                    ST_DEVADR: begin
                                        if (shreg[7:1] == dev_addr) begin
                                            sda_oe <= 1'b1;
                                            rd_req <= shreg[0];
                                        end else begin
                                            state <= ST_IDLE;
                                        end
                                    end
                                    ST_REGADR: begin
                                        sda_oe <= 1'b1;
                                        ptr    <= shreg[PTR_W-1:0];
                                    end
                                    default: begin
                                        sda_oe <= 1'b1;
                                        ptr    <= ptr + 1'b1;
                                    end
                                endcase
                            end
                        end else if (scl_fall && ack_ph) begin
                            ack_ph <= 1'b0;
                            cnt    <= '0;
                            if (state == ST_DEVADR && rd_req) begin
                                state  <= ST_RDATA;
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[DATA_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= (state == ST_DEVADR) ? ST_REGADR : ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && cnt < BIT_CNT_W'(8)) begin
                            cnt <= cnt + BIT_CNT_W'(1);
                        end else if (scl_rise && ack_ph) begin
                            mack <= ~sda_s;
                        end else if (scl_fall && cnt < BIT_CNT_W'(8)) begin
                            txreg  <= txreg << 1;
                            sda_oe <= ~txreg[DATA_W-2];
                        end else if (byte_end) begin
                            ack_ph     <= 1'b1;
                            sda_oe     <= 1'b0;
                            ptr        <= ptr + 1'b1;
                            stat_pulse <= (ptr == IDX_STATUS);
                        end else if (scl_fall && ack_ph) begin
                            ack_ph <= 1'b0;
                            cnt    <= '0;
                            if (mack) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[DATA_W-1];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
// Top level: strap latch, bus synchronizer, protocol engine and register bank.
// Assumes strap_sel is stable while rst_n is low and SCL periods span several clocks.
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [4:0] ADDR_UPPER  = 5'b01100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [1:0]        strap_sel,
    input  logic              uvlo,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] cmd_reg,
    output logic [DATA_W-1:0] dim_reg,
    output logic [DATA_W-1:0] aux_reg,
    output logic              stat_rd_pulse
);
    logic [1:0]                    strap_q;
    logic [6:0]                    dev_addr;
    logic                          sda_s;
    logic                          scl_rise;
    logic                          scl_fall;
    logic                          start_det;
    logic                          stop_det;
    logic                          wr_en;
    logic [PTR_W-1:0]              ptr;
    logic [DATA_W-1:0]             shreg;
    logic [DATA_W-1:0]             rd_data;
    logic [NUM_RW-1:0][DATA_W-1:0] rw_out;

    // Strap capture: loads only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_sel;
    end

    assign dev_addr = {ADDR_UPPER, strap_q};

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .dev_addr   (dev_addr),
        .uvlo       (uvlo),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .wr_en      (wr_en),
        .ptr        (ptr),
        .shreg      (shreg),
        .stat_pulse (stat_rd_pulse)
    );

    i2c_tgt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ptr    (ptr),
        .wr_data   (shreg),
        .rd_ptr    (ptr),
        .status_in (status_in),
        .rd_data   (rd_data),
        .rw_out    (rw_out)
    );

    assign cmd_reg = rw_out[0];
    assign dim_reg = rw_out[1];
    assign aux_reg = rw_out[2];
endmodule

// File: rtl/i2c_reg_target_chk.sv
// Cycle-level properties of the register target, attached by bind.
// Assumes access to the top's internal bus-event nets and strap latch.
module i2c_reg_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       stat_rd_pulse,
    input logic [7:0] cmd_reg,
    input logic [7:0] dim_reg,
    input logic [7:0] aux_reg,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic [1:0] strap_q
);
    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q)); // R1

    AST_SDA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R3

    AST_BUS_EVENT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_oe); // R3

    AST_REG_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_reg != $past(cmd_reg)) || (dim_reg != $past(dim_reg)) || (aux_reg != $past(aux_reg)))
        |-> $past(scl_fall)); // R4

    AST_STAT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_pulse |=> !stat_rd_pulse); // R8

    AST_STAT_PULSE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_pulse |-> $past(scl_fall)); // R8
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sda_oe        (sda_oe),
    .stat_rd_pulse (stat_rd_pulse),
    .cmd_reg       (cmd_reg),
    .dim_reg       (dim_reg),
    .aux_reg       (aux_reg),
    .scl_fall      (scl_fall),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .strap_q       (strap_q)
);

// File: tb/test_i2c_reg_target.sv
// Self-checking bench: a vector table of single writes and read-backs, then directed cases.
module test_i2c_reg_target;
    localparam int CLK_PERIOD = 10;
    localparam int BQ         = 6;
    localparam int WATCHDOG   = 150000;
    localparam logic [7:0] STATUS_VAL = 8'h5C;
    localparam int NVEC = 6;
    // Each entry: {register address byte, data written, value expected on read-back}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 8'h3C, 8'h3C},
        {8'h01, 8'hA5, 8'hA5},
        {8'h02, 8'h81, 8'h81},
        {8'h03, 8'hFF, STATUS_VAL},
        {8'h05, 8'h77, 8'h77},
        {8'h00, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [1:0] strap_sel = 2'b10;
    logic       uvlo = 1'b0;
    logic [7:0] status_in = STATUS_VAL;
    logic       sda_oe;
    logic [7:0] cmd_reg, dim_reg, aux_reg;
    logic       stat_rd_pulse;
    logic       sda_line;
    int         n_checks = 0;
    int         n_fails = 0;
    int         pulse_cnt = 0;
    logic [6:0] dev = 7'h32;

    assign sda_line = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_reg_target i_i2c_reg_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_drv),
        .sda_in        (sda_line),
        .sda_oe        (sda_oe),
        .strap_sel     (strap_sel),
        .uvlo          (uvlo),
        .status_in     (status_in),
        .cmd_reg       (cmd_reg),
        .dim_reg       (dim_reg),
        .aux_reg       (aux_reg),
        .stat_rd_pulse (stat_rd_pulse)
    );

    // Count status-read strobes, sampled away from the active edge.
    always @(negedge clk) if (stat_rd_pulse) pulse_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(BQ);
        scl_drv = 1'b1; tick(BQ);
        sda_drv = 1'b0; tick(BQ);
        scl_drv = 1'b0; tick(BQ);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(BQ);
        scl_drv = 1'b1; tick(BQ);
        sda_drv = 1'b1; tick(BQ);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b;    tick(BQ);
        scl_drv = 1'b1; tick(BQ);
        scl_drv = 1'b0; tick(1);
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; tick(BQ);
        scl_drv = 1'b1; tick(BQ);
        b = sda_line;
        scl_drv = 1'b0; tick(1);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        acked = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            v[i] = x;
        end
        send_bit(~give_ack);
    endtask

    task automatic wr_one(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                          output logic a_ack, output logic d_ack);
        logic k;
        bus_start();
        send_byte({a, 1'b0}, a_ack);
        send_byte(r, k);
        send_byte(d, d_ack);
        bus_stop();
    endtask

    task automatic rd_open(input logic [6:0] a, input logic [7:0] r, output logic ok);
        logic k1, k2, k3;
        bus_start();
        send_byte({a, 1'b0}, k1);
        send_byte(r, k2);
        bus_start();
        send_byte({a, 1'b1}, k3);
        ok = k1 & k2 & k3;
    endtask

    task automatic rd_one(input logic [7:0] r, output logic [7:0] v);
        logic ok;
        rd_open(dev, r, ok);
        recv_byte(v, 1'b0);
        bus_stop();
    endtask

    task automatic do_reset(input logic [1:0] strap);
        rst_n = 1'b0;
        strap_sel = strap;
        tick(5);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired before the run completed");
        finish_run();
    end

    initial begin
        logic aa, da, ok;
        logic [7:0] v;
        logic [23:0] snap, expv;

        do_reset(2'b10);
        dev = 7'h32;
        // R9: reset state
        check("R9 reset regs", {cmd_reg, dim_reg, aux_reg}, 24'h0);
        check("R9 reset sda", sda_oe, 1'b0);

        // Vector table: single write then single read-back (R4, R5, R6, R7)
        for (int n = 0; n < NVEC; n++) begin
            snap = {cmd_reg, dim_reg, aux_reg};
            expv = snap;
            case (VEC[n][17:16])
                2'd0: expv[23:16] = VEC[n][15:8];
                2'd1: expv[15:8]  = VEC[n][15:8];
                2'd2: expv[7:0]   = VEC[n][15:8];
                default: ;
            endcase
            wr_one(dev, VEC[n][23:16], VEC[n][15:8], aa, da);
            check("R4 data ack", {aa, da}, 2'b11);
            check("R4 R5 R6 register ports", {cmd_reg, dim_reg, aux_reg}, expv);
            rd_one(VEC[n][23:16], v);
            check("R7 read-back", v, VEC[n][7:0]);
        end

        // R5 R6: burst write starting at index 1 wraps through status to index 0
        bus_start();
        send_byte({dev, 1'b0}, aa);
        send_byte(8'h01, aa);
        send_byte(8'h11, aa);
        send_byte(8'h22, aa);
        send_byte(8'h33, da);
        check("R6 status write acked", da, 1'b1);
        send_byte(8'h44, aa);
        bus_stop();
        check("R5 burst write wrap", {cmd_reg, dim_reg, aux_reg}, {8'h44, 8'h11, 8'h22});

        // R7 R8: burst read aux, status, cmd, dim with a final missing acknowledge
        pulse_cnt = 0;
        rd_open(dev, 8'h02, ok);
        check("R2 read address acked", ok, 1'b1);
        recv_byte(v, 1'b1);
        check("R7 burst byte aux", v, 8'h22);
        check("R8 no strobe before status", pulse_cnt, 0);
        recv_byte(v, 1'b1);
        check("R7 burst byte status", v, STATUS_VAL);
        check("R8 strobe after status", pulse_cnt, 1);
        recv_byte(v, 1'b1);
        check("R5 burst read wrap cmd", v, 8'h44);
        recv_byte(v, 1'b0);
        check("R7 burst byte dim", v, 8'h11);
        tick(4);
        check("R7 released after nack", sda_oe, 1'b0);
        bus_stop();
        check("R8 single strobe total", pulse_cnt, 1);

        // R2: non-matching address is ignored
        wr_one(7'h30, 8'h00, 8'hEE, aa, da);
        check("R2 foreign address nack", {aa, da}, 2'b00);
        check("R2 foreign write ignored", cmd_reg, 8'h44);

        // R10: undervoltage at the address slot
        uvlo = 1'b1;
        wr_one(dev, 8'h00, 8'h99, aa, da);
        check("R10 no ack under uvlo", aa, 1'b0);
        check("R10 cmd unchanged", cmd_reg, 8'h44);
        uvlo = 1'b0;

        // R10: undervoltage arrives before the data byte's acknowledge
        bus_start();
        send_byte({dev, 1'b0}, aa);
        send_byte(8'h02, aa);
        uvlo = 1'b1;
        send_byte(8'h5A, da);
        bus_stop();
        uvlo = 1'b0;
        check("R10 data nack under uvlo", da, 1'b0);
        check("R10 aux unchanged", aux_reg, 8'h22);

        // R1 R9: new strap at reset, strap changes afterwards are ignored
        do_reset(2'b01);
        check("R9 regs cleared again", {cmd_reg, dim_reg, aux_reg}, 24'h0);
        strap_sel = 2'b10;
        tick(3);
        wr_one(7'h32, 8'h00, 8'h12, aa, da);
        check("R1 late strap ignored", aa, 1'b0);
        wr_one(7'h31, 8'h00, 8'h12, aa, da);
        check("R1 strapped address acked", aa, 1'b1);
        check("R1 write via strapped address", cmd_reg, 8'h12);

        finish_run();
    end
endmodule